// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit with Saturation and Halving

This unit adds or subtracts two 32-bit operands that are split into independent lanes: four 8-bit lanes, two 16-bit lanes or one 32-bit lane. Each lane can be read as signed or unsigned. Three arithmetic behaviours are available. Plain mode wraps the lane result and reports overflow. Clamping mode limits each lane to its representable range. Halving mode returns the sum or difference divided by two, with optional round-up.

One operation is accepted per clock on `op_valid`. The packed result appears one clock later. With it comes a mask/value pair for an external control register. The owner of that register clears the bits selected by the mask and then ORs in the value. The only bit ever touched is the overflow indicator at position 4 of an 8-bit flag field. A two-state sequencer tracks the output. `ST_IDLE` means no result is presented. `ST_RESULT` means a fresh result is on the outputs. `op_valid` high moves the sequencer from `ST_IDLE` to `ST_RESULT` and keeps it there. `op_valid` low moves it from `ST_RESULT` back to `ST_IDLE`.

Top module: `simd_addsub_unit`

## Requirements
- R1: `op_fmt` selects the lane split. Code 0 gives four 8-bit lanes, code 1 gives two 16-bit lanes, and code 2 gives one 32-bit lane. Code 3 behaves as code 2. Lane i occupies bits [w*(i+1)-1 : w*i], counted from the least significant end, and lanes never carry into each other.
- R2: With `op_sat`=0 and `op_half`=0, each lane returns the low w bits of the exact sum or difference. A lane whose exact result is outside its range still counts as overflow.
- R3: With `op_sat`=1, `op_signed`=1 and `op_half`=0, a lane result above 2^(w-1)-1 is clamped to that value. A result below -2^(w-1) is clamped to -2^(w-1).
- R4: With `op_sat`=1, `op_signed`=0 and `op_half`=0, a lane result is clamped into 0 .. 2^w-1.
- R5: With `op_half`=1, each lane returns (a±b) arithmetically shifted right by one, computed on the extended lane value. An unsigned difference is taken as negative before the shift.
- R6: With `op_half`=1 and `op_round`=1, 1 is added to the extended sum or difference before the shift. With `op_half`=0, `op_round` has no effect on any output.
- R7: A halving operation never reports overflow, whatever its operands.
- R8: If any lane of a result overflows, `flag_mask` and `flag_value` both equal 8'h10, with only bit 4 set. Otherwise both are 8'h00.
- R9: The result of an operation issued with `op_valid` appears on `res_data` at the next clock, with `res_valid` high for that cycle. After a cycle without `op_valid`, `res_valid` is 0, `res_data` holds its last value, and both flag outputs are 0.
- R10: After reset, `res_valid` is 0, `res_data` is 0 and both flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Issue an operation this cycle |
| op_a | input | 32 | First operand (minuend for subtract) |
| op_b | input | 32 | Second operand |
| op_fmt | input | 2 | Lane split: 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_signed | input | 1 | 1 = lanes are signed |
| op_sat | input | 1 | 1 = clamp results to lane range |
| op_half | input | 1 | 1 = halving mode |
| op_round | input | 1 | Round up in halving mode |
| res_valid | output | 1 | Result present (sequencer in `ST_RESULT`) |
| res_data | output | 32 | Packed lane results |
| flag_mask | output | 8 | Flag-field bits to clear |
| flag_value | output | 8 | Flag-field bits to set after clearing |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath and an 8-bit flag field with the overflow indicator at bit 4. All three lane widths are therefore live in one build, including the 32-bit lane, where the carry-out and sign logic is widest. Directed operands reach every clamp bound: signed maximum plus one, signed minimum minus one, unsigned 0 minus 1 and unsigned all-ones plus one. They also cover rounding and truncation of odd halving results. A seeded sweep of mixed modes and formats is compared against a lane-by-lane integer model.

// File: rtl/simd_pkg.sv
package simd_pkg;
    typedef enum logic [1:0] {
        FMT_BYTE = 2'd0,
        FMT_HALF = 2'd1,
        FMT_WORD = 2'd2,
        FMT_RSVD = 2'd3
    } lane_fmt_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } out_state_e;

    typedef struct packed {
        logic sub;
        logic sgn;
        logic sat;
        logic half;
        logic rnd;
    } lane_ctl_t;
endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    input  lane_ctl_t     ctl,
    output logic [LW-1:0] res,
    output logic          ovf
);
    localparam int EW = LW + 2;
    localparam logic signed [EW-1:0] SMAX = {3'b000, {(LW-1){1'b1}}};
    localparam logic signed [EW-1:0] SMIN = {3'b111, {(LW-1){1'b0}}};
    localparam logic signed [EW-1:0] UMAX = {2'b00, {LW{1'b1}}};

    logic signed [EW-1:0] ea, eb, total, rounded, halved, hi, lo;
    logic                 above, below;

    always_comb begin
        ea      = ctl.sgn ? {{2{a[LW-1]}}, a} : {2'b00, a};
        eb      = ctl.sgn ? {{2{b[LW-1]}}, b} : {2'b00, b};
        total   = ctl.sub ? (ea - eb) : (ea + eb);
        rounded = total + $signed({{(EW-1){1'b0}}, ctl.rnd});
        halved  = rounded >>> 1;
        hi      = ctl.sgn ? SMAX : UMAX;
        lo      = ctl.sgn ? SMIN : '0;
        above   = total > hi;
        below   = total < lo;
        ovf     = !ctl.half && (above || below);
        if (ctl.half)
            res = halved[LW-1:0];
        else if (ctl.sat && above)
            res = hi[LW-1:0];
        else if (ctl.sat && below)
            res = lo[LW-1:0];
        else
            res = total[LW-1:0];
    end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
    import simd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LW     = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  lane_ctl_t         ctl,
    output logic [DATA_W-1:0] res,
    output logic              any_ovf
);
    localparam int NL = DATA_W / LW;

    logic [NL-1:0] lane_ovf;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        simd_lane_alu #(.LW(LW)) u_lane (
            .a   (a[i*LW +: LW]),
            .b   (b[i*LW +: LW]),
            .ctl (ctl),
            .res (res[i*LW +: LW]),
            .ovf (lane_ovf[i])
        );
    end

    assign any_ovf = |lane_ovf;
endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
    import simd_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int FLAG_W   = 8,
    parameter int FLAG_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [1:0]        op_fmt,
    input  logic              op_sub,
    input  logic              op_signed,
    input  logic              op_sat,
    input  logic              op_half,
    input  logic              op_round,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [FLAG_W-1:0] flag_mask,
    output logic [FLAG_W-1:0] flag_value
);
    localparam int BYTE_W = DATA_W / 4;
    localparam int HALF_W = DATA_W / 2;
    localparam logic [FLAG_W-1:0] OVF_ONE = FLAG_W'(1) << FLAG_BIT;

    lane_ctl_t         ctl;
    logic [DATA_W-1:0] res_b, res_h, res_w, res_sel;
    logic              ovf_b, ovf_h, ovf_w, ovf_sel;
    logic              ovf_q;
    out_state_e        state_q, state_d;

    assign ctl = '{sub: op_sub, sgn: op_signed, sat: op_sat,
                   half: op_half, rnd: op_round};

    simd_lane_bank #(.DATA_W(DATA_W), .LW(BYTE_W)) u_bank_b (
        .a(op_a), .b(op_b), .ctl(ctl), .res(res_b), .any_ovf(ovf_b));
    simd_lane_bank #(.DATA_W(DATA_W), .LW(HALF_W)) u_bank_h (
        .a(op_a), .b(op_b), .ctl(ctl), .res(res_h), .any_ovf(ovf_h));
    simd_lane_bank #(.DATA_W(DATA_W), .LW(DATA_W)) u_bank_w (
        .a(op_a), .b(op_b), .ctl(ctl), .res(res_w), .any_ovf(ovf_w));

    always_comb begin
        unique case (lane_fmt_e'(op_fmt))
            FMT_BYTE: begin res_sel = res_b; ovf_sel = ovf_b; end
            FMT_HALF: begin res_sel = res_h; ovf_sel = ovf_h; end
            default:  begin res_sel = res_w; ovf_sel = ovf_w; end
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (op_valid)  state_d = ST_RESULT;
            ST_RESULT: if (!op_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_data <= '0;
            ovf_q    <= 1'b0;
        end else if (op_valid) begin
            res_data <= res_sel;
            ovf_q    <= ovf_sel;
        end
    end

    // outputs
    always_comb begin
        res_valid  = (state_q == ST_RESULT);
        flag_mask  = (res_valid && ovf_q) ? OVF_ONE : '0;
        flag_value = flag_mask;
    end
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
    parameter int DATA_W   = 32,
    parameter int FLAG_W   = 8,
    parameter int FLAG_BIT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [DATA_W-1:0] op_a,
    input logic [1:0]        op_fmt,
    input logic              op_sub,
    input logic              op_signed,
    input logic              op_sat,
    input logic              op_half,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic [FLAG_W-1:0] flag_mask,
    input logic [FLAG_W-1:0] flag_value
);
    p_flag_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_mask != '0) |-> (flag_mask == (FLAG_W'(1) << FLAG_BIT) && flag_value == flag_mask));

    p_half_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_half) |=> (flag_mask == '0));

    p_issue_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && $stable(res_data) && flag_value == '0));

    p_usat_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_signed && op_sat && !op_sub && !op_half && op_fmt[1])
        |=> (res_data >= $past(op_a)));
endmodule

bind simd_addsub_unit simd_addsub_chk #(
    .DATA_W(DATA_W), .FLAG_W(FLAG_W), .FLAG_BIT(FLAG_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a),
    .op_fmt(op_fmt), .op_sub(op_sub), .op_signed(op_signed),
    .op_sat(op_sat), .op_half(op_half), .res_valid(res_valid),
    .res_data(res_data), .flag_mask(flag_mask), .flag_value(flag_value)
);

// File: tb/simd_addsub_unit_bench.sv
`timescale 1ns/1ps
module simd_addsub_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [1:0]  op_fmt = '0;
    logic        op_sub = 0, op_signed = 0, op_sat = 0, op_half = 0, op_round = 0;
    logic        res_valid;
    logic [31:0] res_data;
    logic [7:0]  flag_mask, flag_value;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    simd_addsub_unit u_simd_addsub_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
        .op_fmt(op_fmt), .op_sub(op_sub), .op_signed(op_signed), .op_sat(op_sat),
        .op_half(op_half), .op_round(op_round), .res_valid(res_valid),
        .res_data(res_data), .flag_mask(flag_mask), .flag_value(flag_value)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] a, input logic [31:0] b, input int fmt,
                                  input bit sub, input bit sgn, input bit sat, input bit hlv,
                                  input bit rnd, output logic [31:0] r, output bit ov);
        int nb = (fmt == 0) ? 8 : (fmt == 1) ? 16 : 32;
        longint msk = (longint'(1) << nb) - 1;
        r = '0;
        ov = 0;
        for (int i = 0; i < 32 / nb; i++) begin
            longint x = (longint'(a) >> (i * nb)) & msk;
            longint y = (longint'(b) >> (i * nb)) & msk;
            longint s, hi, lo;
            if (sgn && x[nb-1]) x = x - (longint'(1) << nb);
            if (sgn && y[nb-1]) y = y - (longint'(1) << nb);
            s  = sub ? x - y : x + y;
            hi = sgn ? (longint'(1) << (nb - 1)) - 1 : msk;
            lo = sgn ? -(longint'(1) << (nb - 1)) : 0;
            if (hlv) begin
                s = (s + (rnd ? 1 : 0)) >>> 1;
            end else if (s > hi) begin
                ov = 1;
                if (sat) s = hi;
            end else if (s < lo) begin
                ov = 1;
                if (sat) s = lo;
            end
            r = r | 32'((s & msk) << (i * nb));
        end
    endfunction

    // issue one op and check result one clock later
    task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                          input int fmt, input bit sub, input bit sgn, input bit sat,
                          input bit hlv, input bit rnd);
        logic [31:0] er;
        bit          eo;
        model(a, b, fmt, sub, sgn, sat, hlv, rnd, er, eo);
        @(negedge clk);
        op_valid = 1; op_a = a; op_b = b; op_fmt = 2'(fmt);
        op_sub = sub; op_signed = sgn; op_sat = sat; op_half = hlv; op_round = rnd;
        @(negedge clk);
        op_valid = 0;
        check({req, " data"}, res_data, er);
        check({req, " mask"}, {24'd0, flag_mask}, eo ? 32'h10 : 32'h0);
        check({req, " value"}, {24'd0, flag_value}, eo ? 32'h10 : 32'h0);
        check({req, " valid"}, {31'd0, res_valid}, 32'd1);
    endtask

    task automatic t_reset();
        check("R10 valid", {31'd0, res_valid}, 32'd0);
        check("R10 data", res_data, 32'd0);
        check("R10 mask", {24'd0, flag_mask}, 32'd0);
    endtask

    task automatic t_layout();
        run_op("R1 bytes", 32'h01020304, 32'h10203040, 0, 0, 0, 0, 0, 0);
        run_op("R1 halves no carry", 32'h0000FFFF, 32'h00000001, 1, 0, 0, 0, 0, 0);
        run_op("R1 reserved fmt", 32'h0000FFFF, 32'h00000001, 3, 0, 0, 0, 0, 0);
    endtask

    task automatic t_wrap();
        run_op("R2 s8 max+1", 32'h0000007F, 32'h00000001, 0, 0, 1, 0, 0, 0);
        run_op("R2 u16 0-1", 32'h00000000, 32'h00000001, 1, 1, 0, 0, 0, 0);
    endtask

    task automatic t_sat_signed();
        run_op("R3 s16 min-1", 32'h80008000, 32'h00010001, 1, 1, 1, 1, 0, 0);
        run_op("R3 s32 max+1", 32'h7FFFFFFF, 32'h00000001, 2, 0, 1, 1, 0, 0);
        run_op("R3 s8 mixed", 32'h7F80407F, 32'h01FF4080, 0, 0, 1, 1, 0, 0);
    endtask

    task automatic t_sat_unsigned();
        run_op("R4 u8 0-1", 32'h00000000, 32'h01010101, 0, 1, 0, 1, 0, 0);
        run_op("R4 u32 max+1", 32'hFFFFFFFF, 32'h00000001, 2, 0, 0, 1, 0, 0);
    endtask

    task automatic t_halve();
        run_op("R5 s8 halve", 32'h7F7F8081, 32'h7F018080, 0, 0, 1, 0, 1, 0);
        run_op("R5 u16 halve sub", 32'h00000003, 32'h00050000, 1, 1, 0, 0, 1, 0);
        run_op("R6 round up", 32'h00030003, 32'h00000000, 1, 0, 1, 0, 1, 1);
        run_op("R6 round ignored", 32'h0000007F, 32'h00000001, 0, 0, 1, 0, 0, 1);
        run_op("R7 halve no flag", 32'h7FFFFFFF, 32'h7FFFFFFF, 2, 0, 1, 1, 1, 1);
    endtask

    task automatic t_hold();
        logic [31:0] last;
        run_op("R9 issue", 32'h7F000000, 32'h01000000, 0, 0, 1, 0, 0, 0);
        last = res_data;
        @(negedge clk);
        check("R9 idle valid", {31'd0, res_valid}, 32'd0);
        check("R9 idle hold", res_data, last);
        check("R9 idle flag", {24'd0, flag_value}, 32'd0);
    endtask

    task automatic t_sweep();
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = $urandom;
            int          f = n % 3;
            bit          h = (n % 5) == 0;
            run_op("R2 R3 R4 R5 sweep", a, b, f, n[0], n[1], n[2], h, n[3]);
        end
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(7));
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_wrap();
        t_sat_signed();
        t_sat_unsigned();
        t_halve();
        t_hold();
        t_sweep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule